// File: doc/BRIEF.md
# Interleaved Converter Output Multiplexer with Overrange Saturation

This block sits behind a bank of time-interleaved converter sections. Each section takes its turn at sampling the input, converts over many cycles, and leaves a 13-bit result on its own slice of a wide input bus. On every clock the block picks the one section whose result is due, applies the overrange rule, and registers the word. The top bit of a section result marks a value beyond positive full scale. In that case the 12 data bits are forced to all ones and an overrange flag is raised. Otherwise the low 12 bits pass through as straight binary.

A rotating slot counter drives the timing. The counter names the section that samples in the current cycle. The selector reads the section that sampled 13 cycles earlier, so a sample taken in one cycle reaches the outputs exactly 14 cycles later. The data and overrange outputs can be released to high impedance by an active-high disable input. The registered pipeline keeps running while the outputs are released. A valid flag stays low until the first sampled word has travelled the whole latency after reset.

Top module: `ilv_out_mux`

## Requirements
- R1: While reset is held, `sample_slot` is 0. After reset it rises by one each clock and wraps from 17 back to 0. Its value names the section that samples the input during the current cycle.
- R2: Section s occupies bits [13s+12:13s] of `sec_result`. The word presented in cycle c+14 comes from the section that sampled in cycle c. That section's input is read during cycle c+13 and captured on the rising edge that ends it.
- R3: When the selected result has bit 12 clear, `data_out` equals its bits 11:0 in straight binary and `ovr_out` is 0. An input of 0 gives all zeros and 4095 gives all ones.
- R4: When the selected result has bit 12 set (a value of 4096 or more), `ovr_out` is 1 and all 12 bits of `data_out` are 1.
- R5: While `out_hiz` is 1, `data_out` and `ovr_out` are high impedance. The pipeline keeps running during that time, so the word shown once `out_hiz` returns to 0 is the one R2 calls for.
- R6: `data_valid` is 0 during reset and for the first 14 cycles after it (cycles 0 to 13). It is 1 from cycle 14 on.
- R7: While reset is held, the registered data and overrange bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_result | input | 234 | 18 section results of 13 bits each; section s at bits [13s+12:13s] |
| out_hiz | input | 1 | 1 releases data_out and ovr_out to high impedance |
| sample_slot | output | 5 | Index of the section sampling in the current cycle |
| data_out | output | 12 | Registered straight-binary word, tri-stated |
| ovr_out | output | 1 | Registered overrange flag, tri-stated |
| data_valid | output | 1 | High once the first sampled word has reached the outputs |

## Verification
The hardest case to reach is a wrong section choice that happens to show the right value. That cannot be caught unless every section other than the due one carries a different word. The stimulus therefore fills all other slices with a corrupted copy in every cycle. It places the genuine word only in the slice of the section that sampled 13 cycles earlier. Across about 8200 cycles the genuine words step through all 8192 codes of 13 bits by a fixed odd stride. This covers both sides of the overrange boundary in every section position. A window with the outputs released is placed mid-run, so that the first word after re-enabling is also compared.

// File: rtl/ilv_pkg.sv
`timescale 1ns/1ps
// ilv_pkg: shared helpers for the interleaved output multiplexer.
// Assumes the latency is at least 2 cycles.
package ilv_pkg;

    // Distance from the sampling section to the section being read.
    function automatic int unsigned ilv_read_offset(input int unsigned nsec,
                                                    input int unsigned lat);
        return (nsec - ((lat - 1) % nsec)) % nsec;
    endfunction

endpackage

// File: rtl/ilv_slot_seq.sv
`timescale 1ns/1ps
// ilv_slot_seq: rotating sample-slot counter, 0..NSEC-1.
// Assumes a synchronous active-low reset that returns it to slot 0.
module ilv_slot_seq #(
    parameter int NSEC = 18,
    localparam int SW = $clog2(NSEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] slot_o
);

    logic [SW-1:0] slot_q;

    // Advance by one slot per clock, wrapping at the last section.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= '0;
        else if (slot_q == SW'(NSEC - 1))
            slot_q <= '0;
        else
            slot_q <= slot_q + 1'b1;
    end

    assign slot_o = slot_q;

endmodule

// File: rtl/ilv_sel_mux.sv
`timescale 1ns/1ps
// ilv_sel_mux: picks the section result due for transfer.
// The due section is OFFS slots ahead of the sampling slot, modulo NSEC.
// Assumes slot_i < NSEC.
module ilv_sel_mux #(
    parameter int NSEC = 18,
    parameter int RW   = 13,
    parameter int OFFS = 5,
    localparam int SW  = $clog2(NSEC)
) (
    input  logic [NSEC*RW-1:0] bus_i,
    input  logic [SW-1:0]      slot_i,
    output logic [RW-1:0]      word_o
);

    logic [SW:0]   sum;
    logic [SW-1:0] idx;
    logic [RW-1:0] words [NSEC];

    // Split the flat bus into one word per section.
    for (genvar g = 0; g < NSEC; g++) begin : g_split
        assign words[g] = bus_i[g*RW +: RW];
    end

    // Compute the due index with a single conditional wrap.
    always_comb begin
        sum = {1'b0, slot_i} + (SW+1)'(OFFS);
        if (sum >= (SW+1)'(NSEC))
            idx = SW'(sum - (SW+1)'(NSEC));
        else
            idx = SW'(sum);
    end

    // One-of-NSEC selection.
    always_comb begin
        word_o = '0;
        for (int i = 0; i < NSEC; i++)
            if (idx == SW'(i))
                word_o = words[i];
    end

endmodule

// File: rtl/ilv_ovr_sat.sv
`timescale 1ns/1ps
// ilv_ovr_sat: maps a DW+1 bit result to DW data bits plus an overrange flag.
// Assumes the top bit of the result is set only above positive full scale.
module ilv_ovr_sat #(
    parameter int DW = 12,
    localparam int RW = DW + 1
) (
    input  logic [RW-1:0] word_i,
    output logic [DW-1:0] data_o,
    output logic          ovr_o
);

    // Saturate to all ones when the overrange bit is set.
    always_comb begin
        ovr_o  = word_i[DW];
        data_o = word_i[DW] ? {DW{1'b1}} : word_i[DW-1:0];
    end

endmodule

// File: rtl/ilv_out_mux.sv
`timescale 1ns/1ps
// ilv_out_mux: top of the interleaved output path.
// Each clock it selects the section due for transfer, saturates on
// overrange, registers the word and drives it through tri-state outputs.
// The latency from a sample slot to its output word is LAT cycles.
// Assumes LAT >= 2 and sections that hold their result until read.
module ilv_out_mux #(
    parameter int NSEC = 18,
    parameter int DW   = 12,
    parameter int LAT  = 14,
    localparam int RW   = DW + 1,
    localparam int SW   = $clog2(NSEC),
    localparam int CW   = $clog2(LAT + 1),
    localparam int OFFS = int'(ilv_pkg::ilv_read_offset(NSEC, LAT))
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSEC*RW-1:0] sec_result,
    input  logic               out_hiz,
    output logic [SW-1:0]      sample_slot,
    output wire  [DW-1:0]      data_out,
    output wire                ovr_out,
    output logic               data_valid
);

    logic [SW-1:0] slot_q;
    logic [RW-1:0] sel_word;
    logic [DW-1:0] sat_data;
    logic          sat_ovr;
    logic [DW-1:0] data_q;
    logic          ovr_q;
    logic [CW-1:0] fill_cnt;
    logic          valid_q;

    ilv_slot_seq #(.NSEC(NSEC)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_o (slot_q)
    );

    ilv_sel_mux #(.NSEC(NSEC), .RW(RW), .OFFS(OFFS)) u_sel (
        .bus_i  (sec_result),
        .slot_i (slot_q),
        .word_o (sel_word)
    );

    ilv_ovr_sat #(.DW(DW)) u_sat (
        .word_i (sel_word),
        .data_o (sat_data),
        .ovr_o  (sat_ovr)
    );

    // Output register for the saturated word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else begin
            data_q <= sat_data;
            ovr_q  <= sat_ovr;
        end
    end

    // Count the cycles after reset until the first word reaches the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_cnt <= '0;
            valid_q  <= 1'b0;
        end else begin
            if (fill_cnt != CW'(LAT - 1))
                fill_cnt <= fill_cnt + 1'b1;
            if (fill_cnt == CW'(LAT - 1))
                valid_q <= 1'b1;
        end
    end

    assign sample_slot = slot_q;
    assign data_valid  = valid_q;
    assign data_out    = out_hiz ? {DW{1'bz}} : data_q;
    assign ovr_out     = out_hiz ? 1'bz : ovr_q;

endmodule

// File: rtl/ilv_out_mux_chk.sv
`timescale 1ns/1ps
// ilv_out_mux_chk: assertion checker bound to ilv_out_mux.
// It rebuilds the due section from the slot by the inverse mapping.
module ilv_out_mux_chk #(
    parameter int NSEC = 18,
    parameter int DW   = 12,
    parameter int LAT  = 14,
    localparam int RW   = DW + 1,
    localparam int SW   = $clog2(NSEC),
    localparam int OFFS = int'(ilv_pkg::ilv_read_offset(NSEC, LAT))
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SW-1:0]      slot,
    input logic [NSEC*RW-1:0] bus,
    input logic [DW-1:0]      data_q,
    input logic               ovr_q,
    input logic               valid
);

    logic [RW-1:0] pick;
    logic [DW-1:0] exp_data;

    // Model: section i is due when the slot equals i minus the offset.
    always_comb begin
        pick = '0;
        for (int i = 0; i < NSEC; i++)
            if (int'(slot) == ((i + NSEC - OFFS) % NSEC))
                pick = bus[i*RW +: RW];
        exp_data = pick[DW] ? {DW{1'b1}} : pick[DW-1:0];
    end

    p_slot_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot == SW'(NSEC - 1) |=> slot == '0);

    p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        slot != SW'(NSEC - 1) |=> slot == $past(slot) + 1'b1);

    p_word_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (data_q == $past(exp_data) && ovr_q == $past(pick[DW])));

    p_ovr_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> data_q == {DW{1'b1}});

    p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> valid);

endmodule

bind ilv_out_mux ilv_out_mux_chk #(.NSEC(NSEC), .DW(DW), .LAT(LAT)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .slot   (slot_q),
    .bus    (sec_result),
    .data_q (data_q),
    .ovr_q  (ovr_q),
    .valid  (valid_q)
);

// File: tb/ilv_out_mux_tb.sv
`timescale 1ns/1ps
// ilv_out_mux_tb: exhaustive sweep of all 13-bit codes through the multiplexer.
module ilv_out_mux_tb;

    localparam int NSEC = 18;
    localparam int DW   = 12;
    localparam int RW   = 13;
    localparam int LAT  = 14;
    localparam int NCYC = 8192 + LAT + 20;
    localparam int HZ_LO = 1000;
    localparam int HZ_HI = 1039;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NSEC*RW-1:0] bus = '0;
    logic               hiz = 1'b0;
    logic [4:0]         slot;
    wire  [DW-1:0]      data_w;
    wire                ovr_w;
    logic               valid;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #4 clk = ~clk;

    for (genvar g = 0; g < DW; g++) begin : g_pd
        pulldown (data_w[g]);
    end
    pulldown (ovr_w);

    ilv_out_mux u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sec_result  (bus),
        .out_hiz     (hiz),
        .sample_slot (slot),
        .data_out    (data_w),
        .ovr_out     (ovr_w),
        .data_valid  (valid)
    );

    function automatic logic [RW-1:0] fval(input int k);
        return RW'((k * 2731) % 8192);
    endfunction

    task automatic check(input string req, input int act, input int exp_v, input int cyc);
        nchk++;
        if (act != exp_v) begin
            nerr++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        // Reset state (R7, R1, R6).
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7 data", int'(data_w), 0, -1);
        check("R7 ovr", int'(ovr_w), 0, -1);
        check("R1 reset slot", int'(slot), 0, -1);
        check("R6 reset valid", int'(valid), 0, -1);
        rst_n = 1'b1;
        for (int c = 0; c < NCYC; c++) begin
            if (c > 0) @(negedge clk);
            // Drive inputs for cycle c: the due section gets the genuine word.
            hiz = (c >= HZ_LO && c <= HZ_HI);
            for (int s = 0; s < NSEC; s++)
                bus[s*RW +: RW] = (c >= LAT - 1) ? (fval(c - (LAT - 1)) ^ 13'h1555) : 13'h1FFF;
            if (c >= LAT - 1)
                bus[((c + 5) % NSEC)*RW +: RW] = fval(c - (LAT - 1));
            #1;
            check("R1 slot", int'(slot), c % NSEC, c);
            check("R6 valid", int'(valid), (c >= LAT) ? 1 : 0, c);
            if (hiz) begin
                check("R5 hiz data", int'(data_w), 0, c);
                check("R5 hiz ovr", int'(ovr_w), 0, c);
            end else if (c >= LAT) begin
                logic [RW-1:0] w;
                w = fval(c - LAT);
                if (w[DW]) begin
                    check("R4 sat data", int'(data_w), 4095, c);
                    check("R4 ovr", int'(ovr_w), 1, c);
                end else begin
                    check("R3/R2 data", int'(data_w), int'(w[DW-1:0]), c);
                    check("R3 ovr", int'(ovr_w), 0, c);
                end
            end
        end
        done = 1;
        summary();
        $finish;
    end

endmodule